// File: doc/BRIEF.md
# Reclocker Input Path Selector and Signal Monitor

This block is the digital control logic that sits around a serial retiming stage. On every sample-clock edge it picks one of four serial data inputs and registers it. That registered bit feeds the retiming stage and also serves as the raw bypass path. The block watches the chosen input for transitions and raises a loss-of-signal flag after a programmable quiet interval.

On the output side the block chooses between the retimed bit returned by the retiming stage and the raw sampled bit. The controls follow a fixed priority. A forced bypass overrides everything. Automatic bypass takes effect only while the loop reports that it is unlocked. Muting acts only on the retimed path and drives the output to logic 0. A separate enable gates the recovered clock onto the clock output.

Top module: `rclk_path_sel`

## Requirements
- R1: One edge after the input select `in_sel` is presented, `sel_bit` equals the input it names: value 0 picks `ser_in[0]`, 1 picks `ser_in[1]`, 2 picks `ser_in[2]`, 3 picks `ser_in[3]`.
- R2: `los` goes high once LOS_CYCLES (default 16) sample edges have passed with no value change on `sel_bit` and no change of select. Edges are counted from reset or from the last restart.
- R3: A value change on `sel_bit` clears `los` on the next edge and restarts the quiet count.
- R4: A change of the input select clears `los` and restarts the quiet count, so a stale flag from the previous input is never reported.
- R5: While `force_bypass` is high, `bypass_on` is high and `data_out` carries the registered raw bit `sel_bit`. `auto_bypass` and `pll_locked` have no effect in this state.
- R6: While `force_bypass` is low and `auto_bypass` is high, the output is bypassed exactly when `pll_locked` is low.
- R7: With no bypass in effect and `mute` low, `data_out` follows `retimed_bit` one edge later and `bypass_on` is low.
- R8: With no bypass in effect and `mute` high, `data_out` is logic 0.
- R9: `mute` has no effect on `data_out` while the output is bypassed.
- R10: `clk_out` equals `rec_clk` while `clk_out_en` is high and is 0 otherwise, with no register in the path.
- R11: During reset `data_out`, `bypass_on`, `los` and `sel_bit` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 4 | Serial data inputs |
| in_sel | input | 2 | Index of the active input |
| force_bypass | input | 1 | Force raw path to output |
| auto_bypass | input | 1 | Bypass while loop is unlocked |
| mute | input | 1 | Drive retimed output to 0 |
| pll_locked | input | 1 | Loop lock indication |
| retimed_bit | input | 1 | Bit returned by the retiming stage |
| rec_clk | input | 1 | Recovered clock |
| clk_out_en | input | 1 | Clock output enable |
| sel_bit | output | 1 | Registered selected input bit |
| data_out | output | 1 | Output data |
| los | output | 1 | Loss of signal flag |
| bypass_on | output | 1 | Output currently bypassed |
| clk_out | output | 1 | Gated recovered clock |

## Verification
The assertions check the following on every cycle: the bypass priority, the mute-to-zero rule on the retimed path, the clearing of the flag after a restart, and the fact that the flag never rises before the counter has reached its limit. The clock gate is also checked. Only the bench scenarios can show the exact cycle in which the flag first rises after a long quiet stretch. They also show that a select change from a quiet input to another quiet input restarts the full interval, and that mute leaves bypassed data unchanged while the controls vary together.

// File: rtl/rps_pkg.sv
package rps_pkg;
  // Output is bypassed when forced, or when autobypass is on and loop unlocked.
  function automatic logic path_bypassed(logic force_b, logic auto_b, logic locked);
    return force_b | (auto_b & ~locked);
  endfunction

  // Static level driven while the retimed path is muted.
  function automatic logic muted_level();
    return 1'b0;
  endfunction
endpackage

// File: rtl/rps_in_mux.sv
module rps_in_mux #(
  parameter int N_IN  = 4,
  parameter int SEL_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  ser_in,
  input  logic [SEL_W-1:0] in_sel,
  output logic             samp,
  output logic [SEL_W-1:0] samp_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp     <= 1'b0;
      samp_sel <= '0;
    end else begin
      samp     <= ser_in[in_sel];
      samp_sel <= in_sel;
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_pick
    // R1: the registered bit comes from the input the select named
    a_r1_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sel == SEL_W'(i)) |=> (samp == $past(ser_in[i])));
  end
endmodule

// File: rtl/rps_los_det.sv
module rps_los_det #(
  parameter int SEL_W      = 2,
  parameter int LOS_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp,
  input  logic [SEL_W-1:0] samp_sel,
  output logic             los
);
  localparam int CNT_W = (LOS_CYCLES > 2) ? $clog2(LOS_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOS_CYCLES - 1);

  logic             prev;
  logic [SEL_W-1:0] prev_sel;
  logic [CNT_W-1:0] quiet_cnt;
  logic             seen_toggle;
  logic             seen_reselect;
  logic             restart;

  assign seen_toggle   = (samp != prev);
  assign seen_reselect = (samp_sel != prev_sel);
  assign restart       = seen_toggle | seen_reselect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev      <= 1'b0;
      prev_sel  <= '0;
      quiet_cnt <= '0;
      los       <= 1'b0;
    end else begin
      prev     <= samp;
      prev_sel <= samp_sel;
      if (restart) begin
        quiet_cnt <= '0;
        los       <= 1'b0;
      end else if (quiet_cnt == LAST) begin
        los <= 1'b1;
      end else begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end
    end
  end

  // R3: a transition clears the flag on the next edge
  a_r3_toggle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seen_toggle |=> !los);
  // R4: a select change clears the flag on the next edge
  a_r4_reselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seen_reselect |=> !los);
  // R2: the flag rises only after the counter reached its limit with no restart
  a_r2_rise_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> ($past(quiet_cnt) == LAST));
endmodule

// File: rtl/rps_out_sel.sv
module rps_out_sel
  import rps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic samp,
  input  logic retimed_bit,
  input  logic force_bypass,
  input  logic auto_bypass,
  input  logic pll_locked,
  input  logic mute,
  output logic data_out,
  output logic bypass_on
);
  logic byp_now;
  logic retimed_path;

  assign byp_now      = path_bypassed(force_bypass, auto_bypass, pll_locked);
  assign retimed_path = mute ? muted_level() : retimed_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out  <= 1'b0;
      bypass_on <= 1'b0;
    end else begin
      data_out  <= byp_now ? samp : retimed_path;
      bypass_on <= byp_now;
    end
  end

  // R5: forced bypass wins over everything
  a_r5_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
    force_bypass |=> (bypass_on && data_out == $past(samp)));
  // R6: autobypass with unlocked loop bypasses
  a_r6_auto_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_bypass && !pll_locked) |=> bypass_on);
  // R8: mute on retimed path gives logic 0
  a_r8_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_bypass && !(auto_bypass && !pll_locked) && mute) |=> (!bypass_on && !data_out));
  // R9: mute cannot disturb bypassed data
  a_r9_mute_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_on) |-> (data_out == $past(samp)));
endmodule

// File: rtl/rclk_path_sel.sv
module rclk_path_sel #(
  parameter int N_IN       = 4,
  parameter int LOS_CYCLES = 16,
  localparam int SEL_W     = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  ser_in,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             force_bypass,
  input  logic             auto_bypass,
  input  logic             mute,
  input  logic             pll_locked,
  input  logic             retimed_bit,
  input  logic             rec_clk,
  input  logic             clk_out_en,
  output logic             sel_bit,
  output logic             data_out,
  output logic             los,
  output logic             bypass_on,
  output logic             clk_out
);
  logic [SEL_W-1:0] samp_sel;

  rps_in_mux #(.N_IN(N_IN), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .in_sel(in_sel),
    .samp(sel_bit), .samp_sel(samp_sel));

  rps_los_det #(.SEL_W(SEL_W), .LOS_CYCLES(LOS_CYCLES)) u_los (
    .clk(clk), .rst_n(rst_n), .samp(sel_bit), .samp_sel(samp_sel), .los(los));

  rps_out_sel u_out (
    .clk(clk), .rst_n(rst_n), .samp(sel_bit), .retimed_bit(retimed_bit),
    .force_bypass(force_bypass), .auto_bypass(auto_bypass),
    .pll_locked(pll_locked), .mute(mute),
    .data_out(data_out), .bypass_on(bypass_on));

  assign clk_out = rec_clk & clk_out_en;

  // R10: disabled clock output stays low
  a_r10_clk_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out_en |-> !clk_out);
  // R11: outputs sit at 0 right after reset
  a_r11_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!data_out && !bypass_on && !los && !sel_bit));
endmodule

// File: tb/rclk_path_sel_bench.sv
`timescale 1ns/1ps
module rclk_path_sel_bench;
  localparam int L = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] ser_in = '0;
  logic [1:0] in_sel = '0;
  logic force_bypass = 0, auto_bypass = 0, mute = 0, pll_locked = 0;
  logic retimed_bit = 0, rec_clk = 0, clk_out_en = 0;
  logic sel_bit, data_out, los, bypass_on, clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rclk_path_sel #(.N_IN(4), .LOS_CYCLES(L)) u_rclk_path_sel (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .in_sel(in_sel),
    .force_bypass(force_bypass), .auto_bypass(auto_bypass), .mute(mute),
    .pll_locked(pll_locked), .retimed_bit(retimed_bit), .rec_clk(rec_clk),
    .clk_out_en(clk_out_en), .sel_bit(sel_bit), .data_out(data_out),
    .los(los), .bypass_on(bypass_on), .clk_out(clk_out));

  // Reference model: history of sampled bits and selects, edges since restart.
  bit m_hist_bit[$];
  int m_hist_sel[$];
  int m_quiet;
  bit m_out, m_byp, m_los, m_sel_bit;
  string m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hist_bit = {1'b0, 1'b0};
      m_hist_sel = {0, 0};
      m_quiet = 0; m_out = 0; m_byp = 0; m_los = 0; m_sel_bit = 0;
    end else begin
      bit b_new; bit b_old; bit bp;
      b_new = m_hist_bit[$]; b_old = m_hist_bit[$-1];
      if (b_new != b_old || m_hist_sel[$] != m_hist_sel[$-1]) m_quiet = 0;
      else if (m_quiet < L) m_quiet++;
      m_los = (m_quiet >= L);
      bp = force_bypass || (auto_bypass && !pll_locked);
      m_byp = bp;
      if (bp) m_out = b_new;
      else if (mute) m_out = 0;
      else m_out = retimed_bit;
      if (force_bypass) m_tag = mute ? "R5 R9" : "R5";
      else if (bp) m_tag = mute ? "R6 R9" : "R6";
      else m_tag = mute ? "R8" : (auto_bypass ? "R6 R7" : "R7");
      m_hist_bit.push_back(ser_in[in_sel]);
      m_hist_sel.push_back(int'(in_sel));
      void'(m_hist_bit.pop_front());
      void'(m_hist_sel.pop_front());
      m_sel_bit = m_hist_bit[$];
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1 sel_bit", sel_bit, m_sel_bit);
    chk({m_tag, " data_out"}, data_out, m_out);
    chk({m_tag, " bypass_on"}, bypass_on, m_byp);
    chk("R2 R3 R4 los", los, m_los);
    chk("R10 clk_out", clk_out, rec_clk & clk_out_en);
  endtask

  task automatic drive_rand(bit quiet);
    if (!quiet) ser_in = 4'($urandom);
    force_bypass = ($urandom % 4) == 0;
    auto_bypass  = $urandom % 2;
    pll_locked   = $urandom % 2;
    mute         = $urandom % 2;
    retimed_bit  = $urandom % 2;
    rec_clk      = $urandom % 2;
    clk_out_en   = $urandom % 2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 data_out", data_out, 1'b0);
    chk("R11 bypass_on", bypass_on, 1'b0);
    chk("R11 los", los, 1'b0);
    chk("R11 sel_bit", sel_bit, 1'b0);
    rst_n = 1'b1;
    // Random traffic on every select
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); compare_all();
      if (i % 37 == 0) in_sel = 2'($urandom);
      drive_rand(0);
    end
    // R2 R3: long quiet stretch then a transition
    for (int k = 0; k < 4; k++) begin
      in_sel = 2'(k);
      for (int i = 0; i < L + 8; i++) begin
        @(negedge clk); compare_all(); drive_rand(1);
      end
      ser_in[k] = ~ser_in[k];
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); compare_all(); drive_rand(1);
      end
    end
    // R4: select change between two quiet inputs with equal levels
    ser_in = 4'b0000; in_sel = 2'd0;
    for (int i = 0; i < L + 4; i++) begin
      @(negedge clk); compare_all(); drive_rand(1);
    end
    chk("R4 los high before reselect", los, 1'b1);
    in_sel = 2'd2;
    for (int i = 0; i < L + 4; i++) begin
      @(negedge clk); compare_all(); drive_rand(1);
    end
    // R9: mute during forced bypass with a toggling input
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); compare_all();
      drive_rand(0); force_bypass = 1; mute = 1;
    end
    @(negedge clk); compare_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule